// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns a single block-transfer request into a stream of word transfers. A request carries a base address, a 16-bit register mask and one of four addressing modes. The modes are increment-after, increment-before, decrement-after and decrement-before. From the number of set bits in the mask, the sequencer works out the lowest address of the block. It then emits one beat per accepted handshake, and each beat carries a word address and the index of the register that goes with it. Registers always go out in ascending index order, and addresses always rise by one word per beat. The lowest-numbered register therefore always lands at the lowest address, whatever the mode.

After the last beat, the sequencer raises a one-cycle completion pulse. When the request asked for it, the pulse comes with the updated base value that the register file should write back. A request with an empty mask produces no beats and completes at once with an error flag. The memory and the register file sit outside the block.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `beat_valid`, `done`, `done_err` and `wb_valid` are all 0.
- R2: Mode code 0 (increment-after): the first beat address is the base, and the last is base + 4N − 4, where N is the number of set bits in `req_list`.
- R3: Mode code 1 (increment-before): the first beat address is base + 4, and the last is base + 4N.
- R4: Mode code 2 (decrement-after): the first beat address is base − 4N + 4, and the last is the base.
- R5: Mode code 3 (decrement-before): the first beat address is base − 4N, and the last is base − 4.
- R6: Beat k carries the k-th lowest set bit index of `req_list` as `beat_reg`, and its address is the first address + 4k. Address arithmetic wraps modulo 2^32.
- R7: At completion, `wb_value` is base + 4N for modes 0 and 1 and base − 4N for modes 2 and 3. `wb_valid` is 1 with `done` only when `req_wb` was 1 at acceptance.
- R8: A request with `req_list` = 0 produces no beat. In the cycle after acceptance, `done` and `done_err` are 1 and `wb_valid` is 0.
- R9: A request is accepted only while `req_ready` is 1, and `req_ready` is 1 only when no transfer is in progress. Requests presented during a transfer have no effect on it. While `beat_ready` is 0, `beat_addr` and `beat_reg` hold their values.
- R10: `done` is high for exactly one cycle, in the cycle after the last beat handshake, and exactly N beats are handed over before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_base | input | 32 | Base address |
| req_list | input | 16 | Register mask, bit i selects register i |
| req_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| req_wb | input | 1 | Request base writeback |
| beat_valid | output | 1 | Beat address and register index are valid |
| beat_ready | input | 1 | Consumer takes the current beat |
| beat_addr | output | 32 | Word address of the current beat |
| beat_reg | output | 4 | Register index of the current beat |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was for an empty mask |
| wb_valid | output | 1 | Writeback value is to be applied |
| wb_value | output | 32 | Updated base value |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 16-register mask and 4-byte words. This lets a full 16-register mask exercise every picker stage and the largest span of 64 bytes. With 32-bit addresses, wrap-around tests near zero and near the top of the address space can be run in both directions. The stimulus table covers all four modes with masks of one, two, three, four and sixteen bits. Some of these masks are sparse, so that the index order can be told apart from the address order. On selected rows the bench stalls the consumer and presents conflicting requests while the transfer is running.

// File: rtl/lsm_seq_pkg.sv
package lsm_seq_pkg;

    typedef enum logic [1:0] {
        LSM_INC_AFTER  = 2'd0,
        LSM_INC_BEFORE = 2'd1,
        LSM_DEC_AFTER  = 2'd2,
        LSM_DEC_BEFORE = 2'd3
    } lsm_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FIN
    } lsm_state_e;

    typedef struct packed {
        logic err;
        logic wb_en;
    } lsm_flags_t;

    function automatic logic mode_is_incr(lsm_mode_e m);
        return !m[1];
    endfunction

endpackage

// File: rtl/lsm_span_calc.sv
module lsm_span_calc
    import lsm_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREGS      = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NREGS-1:0]  list,
    input  lsm_mode_e         mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              empty
);
    localparam int CNT_W = $clog2(NREGS + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] span;

    always_comb begin
        count = '0;
        for (int i = 0; i < NREGS; i++) begin
            count = count + CNT_W'(list[i]);
        end
    end

    assign span  = ADDR_W'(count) * STEP;
    assign empty = (count == '0);

    always_comb begin
        unique case (mode)
            LSM_INC_AFTER:  first_addr = base;
            LSM_INC_BEFORE: first_addr = base + STEP;
            LSM_DEC_AFTER:  first_addr = base - span + STEP;
            default:        first_addr = base - span;
        endcase
        wb_addr = mode_is_incr(mode) ? (base + span) : (base - span);
    end

endmodule

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [NREGS-1:0] mask,
    output logic [NREGS-1:0] grant,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    logic [NREGS:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NREGS; i++) begin : g_chain
        assign grant[i]  = mask[i] & ~seen[i];
        assign seen[i+1] = seen[i] | mask[i];
    end

    assign hit = seen[NREGS];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
    import lsm_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREGS      = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [NREGS-1:0]  req_list,
    input  logic [1:0]        req_mode,
    input  logic              req_wb,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [IDX_W-1:0]  beat_reg,
    output logic              done,
    output logic              done_err,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    lsm_state_e        state;
    logic [NREGS-1:0]  remain;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wb_hold;
    lsm_flags_t        flags;

    logic [ADDR_W-1:0] calc_first;
    logic [ADDR_W-1:0] calc_wb;
    logic              calc_empty;
    logic [NREGS-1:0]  grant;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_hit;
    logic              accept;
    logic              fire;
    logic              last_beat;

    lsm_span_calc #(
        .ADDR_W    (ADDR_W),
        .NREGS     (NREGS),
        .WORD_BYTES(WORD_BYTES)
    ) u_span (
        .base      (req_base),
        .list      (req_list),
        .mode      (lsm_mode_e'(req_mode)),
        .first_addr(calc_first),
        .wb_addr   (calc_wb),
        .empty     (calc_empty)
    );

    lsm_low_pick #(
        .NREGS(NREGS)
    ) u_pick (
        .mask (remain),
        .grant(grant),
        .idx  (pick_idx),
        .hit  (pick_hit)
    );

    assign req_ready  = (state == ST_IDLE);
    assign beat_valid = (state == ST_XFER);
    assign beat_addr  = cur_addr;
    assign beat_reg   = pick_idx;
    assign done       = (state == ST_FIN);
    assign done_err   = done & flags.err;
    assign wb_valid   = done & flags.wb_en;
    assign wb_value   = wb_hold;

    assign accept    = req_valid & req_ready;
    assign fire      = beat_valid & beat_ready;
    assign last_beat = ((remain & ~grant) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            remain   <= '0;
            cur_addr <= '0;
            wb_hold  <= '0;
            flags    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_addr    <= calc_first;
                        wb_hold     <= calc_wb;
                        remain      <= req_list;
                        flags.err   <= calc_empty;
                        flags.wb_en <= req_wb & ~calc_empty;
                        state       <= calc_empty ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (fire) begin
                        remain   <= remain & ~grant;
                        cur_addr <= cur_addr + STEP;
                        if (last_beat) state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: stalled beat holds address and register
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg)));

    // R9: no request taken during a transfer
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (beat_valid || done) |-> !req_ready);

    // R6: next beat has a higher register and the next word address
    p_ascend_r6: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready) |=>
            (!beat_valid || ((beat_reg > $past(beat_reg)) && (beat_addr == $past(beat_addr) + STEP))));

    // R6: an active beat always has a register left to transfer
    p_busy_has_reg_r6: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> pick_hit);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: error completion never writes back
    p_err_no_wb_r8: assert property (@(posedge clk) disable iff (rst)
        done_err |-> (done && !wb_valid));

endmodule

// File: tb/lsm_addr_seq_test.sv
module lsm_addr_seq_test;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] list;
        logic [1:0]  mode;
        logic        wb;
        logic [31:0] first;
        logic [31:0] wbv;
        logic        stall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0008_0010, 16'h000E, 2'd0, 1'b1, 32'h0008_0010, 32'h0008_001C, 1'b0},
        '{32'h0000_1000, 16'h8001, 2'd1, 1'b1, 32'h0000_1004, 32'h0000_1008, 1'b1},
        '{32'h0000_2000, 16'h00F0, 2'd2, 1'b0, 32'h0000_1FF4, 32'h0000_1FF0, 1'b0},
        '{32'h0000_3000, 16'hFFFF, 2'd3, 1'b1, 32'h0000_2FC0, 32'h0000_2FC0, 1'b1},
        '{32'h0000_0000, 16'h0001, 2'd3, 1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b0},
        '{32'hFFFF_FFFC, 16'h0003, 2'd0, 1'b1, 32'hFFFF_FFFC, 32'h0000_0004, 1'b1},
        '{32'h0000_0100, 16'h4000, 2'd2, 1'b1, 32'h0000_0100, 32'h0000_00FC, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0;
    logic [15:0] req_list = '0;
    logic [1:0]  req_mode = '0;
    logic        req_wb = 1'b0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [3:0]  beat_reg;
    logic        done;
    logic        done_err;
    logic        wb_valid;
    logic [31:0] wb_value;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [64];
    logic [31:0] rf  [16];

    always #2 clk = ~clk;

    lsm_addr_seq uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_list(req_list), .req_mode(req_mode), .req_wb(req_wb),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_reg(beat_reg),
        .done(done), .done_err(done_err), .wb_valid(wb_valid), .wb_value(wb_value)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic int nth_reg(input logic [15:0] list, input int k);
        int seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (list[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R2 inc-after addr";
            2'd1:    return "R3 inc-before addr";
            2'd2:    return "R4 dec-after addr";
            default: return "R5 dec-before addr";
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int n;
        int k;
        int cyc;
        n = $countones(v.list);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_base  = v.base;
        req_list  = v.list;
        req_mode  = v.mode;
        req_wb    = v.wb;
        @(negedge clk);
        // stalled rows keep presenting a conflicting request during the transfer (R9)
        req_valid = v.stall;
        req_base  = 32'hDEAD_0000;
        req_list  = 16'h0001;
        req_mode  = 2'd1;
        k   = 0;
        cyc = 0;
        while (!done && cyc < 200) begin
            check(beat_valid == 1'b1, "R10 beat expected before done", 32'(beat_valid), 32'd1);
            if (beat_valid) begin
                check(beat_addr == v.first + 32'(4 * k), mode_tag(v.mode), beat_addr, v.first + 32'(4 * k));
                check(32'(beat_reg) == 32'(nth_reg(v.list, k)), "R6 ascending register order",
                      32'(beat_reg), 32'(nth_reg(v.list, k)));
                check(req_ready == 1'b0, "R9 not ready while busy", 32'(req_ready), 32'd0);
                beat_ready = v.stall ? cyc[0] : 1'b1;
                if (beat_ready) begin
                    rf[beat_reg] = mem[beat_addr[7:2]];
                    k++;
                end
            end
            @(negedge clk);
            cyc++;
        end
        beat_ready = 1'b0;
        req_valid  = 1'b0;
        check(done == 1'b1, "R10 done seen", 32'(done), 32'd1);
        check(k == n, "R10 beat count", 32'(k), 32'(n));
        check(done_err == 1'b0, "R8 no error on non-empty list", 32'(done_err), 32'd0);
        check(wb_valid == v.wb, "R7 writeback enable", 32'(wb_valid), 32'(v.wb));
        if (v.wb) check(wb_value == v.wbv, "R7 writeback value", wb_value, v.wbv);
        @(negedge clk);
        check(done == 1'b0, "R10 done single pulse", 32'(done), 32'd0);
        check(req_ready == 1'b1, "R9 ready after completion", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h100 + 32'(i);
        mem[4] = 32'h1;
        mem[5] = 32'h2;
        mem[6] = 32'h3;
        for (int i = 0; i < 16; i++) rf[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        check(beat_valid == 1'b0, "R1 beat_valid after reset", 32'(beat_valid), 32'd0);
        check(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
        check(wb_valid == 1'b0, "R1 wb_valid after reset", 32'(wb_valid), 32'd0);
        check(done_err == 1'b0, "R1 done_err after reset", 32'(done_err), 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v]);
            if (v == 0) begin
                // R2: three-word load from the word-addressed model
                check(rf[1] == 32'h1, "R2 loaded r1", rf[1], 32'h1);
                check(rf[2] == 32'h2, "R2 loaded r2", rf[2], 32'h2);
                check(rf[3] == 32'h3, "R2 loaded r3", rf[3], 32'h3);
            end
        end

        // R8: empty register list
        @(negedge clk);
        req_valid = 1'b1;
        req_base  = 32'h0000_4000;
        req_list  = 16'h0000;
        req_mode  = 2'd0;
        req_wb    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(beat_valid == 1'b0, "R8 no beat for empty list", 32'(beat_valid), 32'd0);
        check(done == 1'b1, "R8 done for empty list", 32'(done), 32'd1);
        check(done_err == 1'b1, "R8 error flag", 32'(done_err), 32'd1);
        check(wb_valid == 1'b0, "R8 no writeback", 32'(wb_valid), 32'd0);
        @(negedge clk);
        check(done == 1'b0, "R10 empty done single pulse", 32'(done), 32'd0);
        check(beat_valid == 1'b0, "R8 still no beat", 32'(beat_valid), 32'd0);

        // R1: reset in the middle of a transfer returns to idle
        req_valid = 1'b1;
        req_base  = 32'h0000_5000;
        req_list  = 16'h00FF;
        req_mode  = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(beat_valid == 1'b0, "R1 beat_valid after mid-transfer reset", 32'(beat_valid), 32'd0);
        check(req_ready == 1'b1, "R1 req_ready after mid-transfer reset", 32'(req_ready), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule